// File: doc/BRIEF.md
# Modulo-Scheduled Loop Branch Controller

This block decides the outcome of the closing branch of a software-pipelined loop and, with the same decision, steers how the pipeline fills and drains. A request arrives with one of four kinds: counted loop with the test at the bottom, counted loop with the test elsewhere, while loop with the test at the bottom, or while loop with the test elsewhere. The block keeps an iteration counter and a drain counter, which software loads directly. For each request it reports whether the branch is taken, the bit to place in the highest rotating stage predicate, a rotate strobe, and the next values of both counters.

Every request selects one of four paths. Kernel starts a new source iteration. Drain retires one remaining stage. Last-rotate performs the final rotation and leaves the loop. Idle is the degenerate case where the drain counter is already zero. Counted requests take the kernel path while the iteration counter is nonzero. While requests take it while the branch predicate input is 1. Results are registered, so they appear one cycle after the request, and the counters update in the same cycle.

Top module: `lp_branch_ctrl`

## Requirements
- R1: After reset, both counters read 0 and the result bundle is all zero, including `res_valid_o`.
- R2: A counted request (kind 0 or 1) with a nonzero iteration counter decrements the iteration counter, keeps the drain counter, sets the stage bit to 1, rotates and continues the loop.
- R3: A request that does not take the kernel path and sees a drain counter above 1 keeps the iteration counter, decrements the drain counter, sets the stage bit to 0, rotates and continues.
- R4: A request that does not take the kernel path and sees a drain counter of exactly 1 sets the drain counter to 0, sets the stage bit to 0, rotates once more and exits.
- R5: A request that does not take the kernel path and sees a drain counter of 0 changes neither counter, sets the stage bit to 0, does not rotate and exits.
- R6: For kinds with bit 0 clear (0 = counted bottom test, 2 = while bottom test), taken is 1 exactly when the loop continues. For kinds with bit 0 set (1 = counted exit test, 3 = while exit test), taken is 1 exactly when the loop exits.
- R7: A while request (kind bit 1 set) never changes the iteration counter, and its stage bit is always 0.
- R8: A while request with predicate 1 keeps the drain counter, rotates and continues.
- R9: A software load of either counter appears on that counter one cycle later. It overrides the branch update of the same cycle, and the other counter still takes its branch update.
- R10: A cycle without a request leaves both counters unchanged and gives a result bundle of all zeros.
- R11: With the iteration counter loaded to 199 and the drain counter to 4, a run of bottom-test counted requests gives 203 requests up to and including the first not-taken one. That final request sees the iteration counter at 0 and the drain counter at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| br_valid_i | input | 1 | Branch request this cycle |
| br_kind_i | input | 2 | Kind: bit 1 = while, bit 0 = exit-polarity |
| br_pred_i | input | 1 | Branch predicate for while kinds |
| iter_wr_i | input | 1 | Software load of iteration counter |
| iter_wdata_i | input | 64 | Iteration counter load value |
| drain_wr_i | input | 1 | Software load of drain counter |
| drain_wdata_i | input | 6 | Drain counter load value |
| res_valid_o | output | 1 | Registered result is for a request |
| res_taken_o | output | 1 | Branch taken |
| res_stage_bit_o | output | 1 | Value for top rotating predicate |
| res_rotate_o | output | 1 | Rotate strobe |
| res_iter_o | output | 64 | Branch-computed next iteration count |
| res_drain_o | output | 6 | Branch-computed next drain count |
| iter_cnt_o | output | 64 | Current iteration counter |
| drain_cnt_o | output | 6 | Current drain counter |

## Verification
On every cycle the assertions check the following. A cleared stage bit without rotation happens only with a drain result of zero. A set stage bit always comes with rotation. While requests leave the iteration result untouched and clear the stage bit. Software loads land one cycle later. Idle cycles hold both counters. The taken polarity of each kind, the exact count of 203 requests in the long counted run, and the interplay of loads with concurrent requests can be shown only by the bench's scenarios, which compare every result with a behavioural model.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {
    KIND_CNT_BOT  = 2'd0,
    KIND_CNT_EXIT = 2'd1,
    KIND_WHL_BOT  = 2'd2,
    KIND_WHL_EXIT = 2'd3
  } br_kind_e;

  typedef enum logic [1:0] {
    PATH_KERNEL = 2'd0,
    PATH_DRAIN  = 2'd1,
    PATH_LAST   = 2'd2,
    PATH_IDLE   = 2'd3
  } lp_path_e;
endpackage

// File: rtl/lp_path_sel.sv
module lp_path_sel
  import lp_pkg::*;
#(
  parameter int ITER_W  = 64,
  parameter int DRAIN_W = 6
) (
  input  logic [1:0]         kind_i,
  input  logic               pred_i,
  input  logic [ITER_W-1:0]  iter_i,
  input  logic [DRAIN_W-1:0] drain_i,
  output lp_path_e           path_o,
  output logic               taken_o,
  output logic               stage_bit_o,
  output logic               rotate_o,
  output logic [ITER_W-1:0]  iter_nxt_o,
  output logic [DRAIN_W-1:0] drain_nxt_o
);
  logic is_while, kern_cond, cont;

  assign is_while  = kind_i[1];
  assign kern_cond = is_while ? pred_i : (iter_i != '0);

  always_comb begin
    if (kern_cond)                       path_o = PATH_KERNEL;
    else if (drain_i > DRAIN_W'(1))      path_o = PATH_DRAIN;
    else if (drain_i == DRAIN_W'(1))     path_o = PATH_LAST;
    else                                 path_o = PATH_IDLE;
  end

  always_comb begin
    iter_nxt_o  = iter_i;
    drain_nxt_o = drain_i;
    stage_bit_o = 1'b0;
    rotate_o    = 1'b1;
    cont        = 1'b0;
    unique case (path_o)
      PATH_KERNEL: begin
        cont = 1'b1;
        if (!is_while) begin
          iter_nxt_o  = iter_i - ITER_W'(1);
          stage_bit_o = 1'b1;
        end
      end
      PATH_DRAIN: begin
        cont        = 1'b1;
        drain_nxt_o = drain_i - DRAIN_W'(1);
      end
      PATH_LAST:  drain_nxt_o = '0;
      default:    rotate_o = 1'b0;
    endcase
  end

  // exit-polarity kinds invert the sense
  assign taken_o = cont ^ kind_i[0];
endmodule

// File: rtl/lp_cnt_reg.sv
module lp_cnt_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         upd_i,
  input  logic [W-1:0] nxt_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (wr_i)  q_o <= wdata_i;
    else if (upd_i) q_o <= nxt_i;
  end

  // R9
  sw_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> q_o == $past(wdata_i));
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !upd_i) |=> $stable(q_o));
endmodule

// File: rtl/lp_branch_ctrl.sv
module lp_branch_ctrl
  import lp_pkg::*;
#(
  parameter int ITER_W  = 64,
  parameter int DRAIN_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               br_valid_i,
  input  logic [1:0]         br_kind_i,
  input  logic               br_pred_i,
  input  logic               iter_wr_i,
  input  logic [ITER_W-1:0]  iter_wdata_i,
  input  logic               drain_wr_i,
  input  logic [DRAIN_W-1:0] drain_wdata_i,
  output logic               res_valid_o,
  output logic               res_taken_o,
  output logic               res_stage_bit_o,
  output logic               res_rotate_o,
  output logic [ITER_W-1:0]  res_iter_o,
  output logic [DRAIN_W-1:0] res_drain_o,
  output logic [ITER_W-1:0]  iter_cnt_o,
  output logic [DRAIN_W-1:0] drain_cnt_o
);
  lp_path_e           path;
  logic               taken, stage_bit, rotate;
  logic [ITER_W-1:0]  iter_nxt;
  logic [DRAIN_W-1:0] drain_nxt;

  lp_path_sel #(.ITER_W(ITER_W), .DRAIN_W(DRAIN_W)) u_sel (
    .kind_i      (br_kind_i),
    .pred_i      (br_pred_i),
    .iter_i      (iter_cnt_o),
    .drain_i     (drain_cnt_o),
    .path_o      (path),
    .taken_o     (taken),
    .stage_bit_o (stage_bit),
    .rotate_o    (rotate),
    .iter_nxt_o  (iter_nxt),
    .drain_nxt_o (drain_nxt)
  );

  lp_cnt_reg #(.W(ITER_W)) u_iter (
    .clk_i, .rst_ni,
    .wr_i (iter_wr_i), .wdata_i (iter_wdata_i),
    .upd_i (br_valid_i), .nxt_i (iter_nxt), .q_o (iter_cnt_o)
  );

  lp_cnt_reg #(.W(DRAIN_W)) u_drain (
    .clk_i, .rst_ni,
    .wr_i (drain_wr_i), .wdata_i (drain_wdata_i),
    .upd_i (br_valid_i), .nxt_i (drain_nxt), .q_o (drain_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || !br_valid_i) begin
      res_valid_o     <= 1'b0;
      res_taken_o     <= 1'b0;
      res_stage_bit_o <= 1'b0;
      res_rotate_o    <= 1'b0;
      res_iter_o      <= '0;
      res_drain_o     <= '0;
    end else begin
      res_valid_o     <= 1'b1;
      res_taken_o     <= taken;
      res_stage_bit_o <= stage_bit;
      res_rotate_o    <= rotate;
      res_iter_o      <= iter_nxt;
      res_drain_o     <= drain_nxt;
    end
  end

  // R5
  no_rot_only_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_rotate_o) |-> (res_drain_o == '0 && !res_stage_bit_o));
  // R2
  stage_needs_rot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_stage_bit_o |-> res_rotate_o);
  // R7
  while_iter_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && br_kind_i[1]) |=> (res_iter_o == $past(iter_cnt_o) && !res_stage_bit_o));
  // R10
  idle_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_valid_i |=> (!res_valid_o && !res_rotate_o && !res_taken_o));
endmodule

// File: tb/lp_branch_ctrl_bench.sv
`timescale 1ns/1ps
module lp_branch_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic br_valid = 0, br_pred = 0, iter_wr = 0, drain_wr = 0;
  logic [1:0] br_kind = 0;
  logic [63:0] iter_wdata = 0;
  logic [5:0] drain_wdata = 0;
  logic res_valid, res_taken, res_stage, res_rot;
  logic [63:0] res_iter, iter_cnt;
  logic [5:0] res_drain, drain_cnt;

  int n_chk = 0, n_fail = 0;
  longint unsigned m_iter = 0;
  int m_drain = 0;

  always #5 clk = ~clk;

  lp_branch_ctrl u_lp_branch_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .br_valid_i(br_valid), .br_kind_i(br_kind),
    .br_pred_i(br_pred), .iter_wr_i(iter_wr), .iter_wdata_i(iter_wdata),
    .drain_wr_i(drain_wr), .drain_wdata_i(drain_wdata),
    .res_valid_o(res_valid), .res_taken_o(res_taken), .res_stage_bit_o(res_stage),
    .res_rotate_o(res_rot), .res_iter_o(res_iter), .res_drain_o(res_drain),
    .iter_cnt_o(iter_cnt), .drain_cnt_o(drain_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare after posedge
  task automatic step(input bit v, input bit [1:0] k, input bit p,
                      input bit iw, input longint unsigned id,
                      input bit dw, input int dd, input string req);
    bit cont, rot, sb, tk;
    longint unsigned ni;
    int nd;
    @(negedge clk);
    br_valid = v; br_kind = k; br_pred = p;
    iter_wr = iw; iter_wdata = id; drain_wr = dw; drain_wdata = 6'(dd);
    ni = m_iter; nd = m_drain; cont = 0; rot = 1; sb = 0;
    if ((k[1] && p) || (!k[1] && m_iter != 0)) begin
      cont = 1;
      if (!k[1]) begin ni = m_iter - 1; sb = 1; end
    end else if (m_drain > 1) begin
      cont = 1; nd = m_drain - 1;
    end else if (m_drain == 1) begin
      nd = 0;
    end else begin
      rot = 0;
    end
    tk = k[0] ? !cont : cont;
    @(posedge clk); #1;
    if (v) begin
      chk(res_valid == 1 && res_taken == tk, req, "taken", res_taken, tk);
      chk(res_stage == sb && res_rot == rot, req, "stage/rot",
          {res_stage, res_rot}, {sb, rot});
      chk(res_iter == ni && res_drain == 6'(nd), req, "res drain", res_drain, nd);
    end else begin
      chk(res_valid == 0 && res_rot == 0 && res_taken == 0, req, "idle res",
          {res_valid, res_rot, res_taken}, 0);
    end
    if (iw) m_iter = id; else if (v) m_iter = ni;
    if (dw) m_drain = dd; else if (v) m_drain = nd;
    chk(iter_cnt == m_iter, req, "iter cnt", iter_cnt, m_iter);
    chk(drain_cnt == 6'(m_drain), req, "drain cnt", drain_cnt, m_drain);
    br_valid = 0; iter_wr = 0; drain_wr = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int nbr;
    longint unsigned last_i;
    int last_d;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(iter_cnt == 0 && drain_cnt == 0 && res_valid == 0 && res_rot == 0,
        "R1", "reset", iter_cnt, 0);
    @(negedge clk); rst_n = 1;

    // R9 load both, R11 long counted run
    step(0, 0, 0, 1, 199, 1, 4, "R9");
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    nbr = 0;
    for (int i = 0; i < 300; i++) begin
      last_i = m_iter; last_d = m_drain;
      step(1, 2'd0, 0, 0, 0, 0, 0, m_iter != 0 ? "R2" : (m_drain > 1 ? "R3" : "R4"));
      nbr++;
      if (!res_taken) break;
    end
    chk(nbr == 203, "R11", "branch count", nbr, 203);
    chk(last_i == 0 && last_d == 1, "R11", "final state drain", last_d, 1);
    // R5 degenerate empty drain, both polarities
    step(1, 2'd0, 0, 0, 0, 0, 0, "R5");
    step(1, 2'd1, 0, 0, 0, 0, 0, "R5");

    // R6 exit-polarity counted loop
    step(0, 0, 0, 1, 2, 1, 3, "R9");
    for (int i = 0; i < 6; i++) step(1, 2'd1, 0, 0, 0, 0, 0, "R6");

    // R7/R8 while loops, iteration counter preset and must stay
    step(0, 0, 0, 1, 77, 1, 3, "R9");
    for (int i = 0; i < 3; i++) step(1, 2'd2, 1, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 4; i++) step(1, 2'd2, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 2, "R9");
    step(1, 2'd3, 1, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 3; i++) step(1, 2'd3, 0, 0, 0, 0, 0, "R4");
    chk(iter_cnt == 77, "R7", "iter untouched", iter_cnt, 77);

    // R9 load vs concurrent branch: iter load wins, drain takes update
    step(0, 0, 0, 1, 5, 1, 2, "R9");
    step(1, 2'd0, 0, 1, 40, 0, 0, "R9");
    step(1, 2'd0, 0, 0, 0, 1, 9, "R9");
    step(1, 2'd0, 0, 1, 0, 1, 1, "R9");
    step(1, 2'd0, 0, 0, 0, 0, 0, "R4");
    // R10 idle cycles hold
    for (int i = 0; i < 3; i++) step(0, 2'd1, 1, 0, 0, 0, 0, "R10");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule